// File: doc/BRIEF.md
# Dual-Clock Reset Sequencer

This block brings a two-clock FIFO out of reset. One active-low reset input, `rstN`, may be asserted and released at any moment with respect to either port clock. The block turns it into a pointer-clear level for each clock domain. That level asserts at once and is removed only on a port clock edge. While reset is held, the block drives each port's flags to their starting values. After release, each port's input-ready flag comes up on a fixed edge of that port's own clock.

Each domain also counts its own clock edges while reset is held. When that domain leaves reset, it reports whether the pulse was too short for a valid reset. The rising edge of `rstN` captures a two-bit select code. That code picks one of four almost-full/almost-empty offsets, which are held as parameters. Pointer and flag arithmetic after reset belongs to the surrounding FIFO.

Top module: `dualclk_rst_init`

## Requirements
- R1: When `rstN` goes low, `ptrClrA` and `ptrClrB` go high at once, without waiting for any clock edge, and stay high while `rstN` is low.
- R2: While `rstN` is low, each port drives `inReady` low, `outReady` low, `nearEmpty` low, `nearFull` high and `mailFree` high.
- R3: After `rstN` rises, `ptrClrX` falls and `inReadyX` rises on the second rising edge of `clkX`, where X is A or B. After the first such edge they are still high and low respectively.
- R4: On the edge given in R3, `shortRstX` is loaded. It becomes 1 if fewer than 4 rising edges of `clkX` occurred while `rstN` was low, and 0 otherwise. At all other times it holds its value.
- R5: The rising edge of `rstN` loads `flagOffset` from `flagSel`. Code 0 gives 4, code 1 gives 8, code 2 gives 16 and code 3 gives 32.
- R6: Changes on `flagSel` while `rstN` stays high have no effect on `flagOffset`.
- R7: The two ports are sequenced independently. Port A's release timing and short-pulse status depend only on `clkA` edges, and port B's depend only on `clkB` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Active-low reset; may change at any time |
| flagSel | input | 2 | Offset select code, captured on the rising edge of rstN |
| ptrClrA | output | 1 | Pointer clear for the port A domain |
| ptrClrB | output | 1 | Pointer clear for the port B domain |
| inReadyA | output | 1 | Port A input-ready (not full) flag |
| inReadyB | output | 1 | Port B input-ready (not full) flag |
| outReadyA | output | 1 | Port A output-ready (not empty) flag, starting value |
| outReadyB | output | 1 | Port B output-ready (not empty) flag, starting value |
| nearEmptyA | output | 1 | Port A almost-empty flag (low = almost empty), starting value |
| nearEmptyB | output | 1 | Port B almost-empty flag (low = almost empty), starting value |
| nearFullA | output | 1 | Port A almost-full flag (low = almost full), starting value |
| nearFullB | output | 1 | Port B almost-full flag (low = almost full), starting value |
| mailFreeA | output | 1 | Port A mailbox-free flag, starting value |
| mailFreeB | output | 1 | Port B mailbox-free flag, starting value |
| shortRstA | output | 1 | Port A reset pulse was too short |
| shortRstB | output | 1 | Port B reset pulse was too short |
| flagOffset | output | 6 | Almost-full/almost-empty offset value |

## Verification
Reset assertion should show up about 1 ns after `rstN` falls, before any clock edge, so the bench samples at that point. Release is due on the second rising edge of each port's own clock after `rstN` rises. The bench therefore checks each port 2 ns after its first and second edges, in two parallel branches, one per clock. The short-pulse flag settles on that same second edge. Its expected value comes from edge counters in the bench that count each clock while `rstN` is low. The offset is read 30 ns after release, after `flagSel` has already moved to another code.

// File: rtl/rstinit_pkg.sv
package rstinit_pkg;
  // Strobes from a domain's control to its datapath
  typedef struct packed {
    logic ptrClr;   // domain still held in reset
    logic relEdge;  // the coming edge releases the domain
    logic cntMet;   // enough edges seen for a valid reset
  } domStrobe_t;
endpackage

// File: rtl/rstinit_ctl.sv
module rstinit_ctl
  import rstinit_pkg::*;
#(
  parameter int MIN_EDGES     = 4,
  parameter int RELEASE_EDGES = 2   // must be 2 or more
) (
  input  logic       clk,
  input  logic       rstN,
  output domStrobe_t strb
);
  // Edges counted while the synced level is high = low edges + release edges
  localparam int THR = MIN_EDGES + RELEASE_EDGES;
  localparam int CW  = $clog2(THR + 1);

  logic [RELEASE_EDGES-1:0] syncQ;
  logic [CW-1:0]            edgeCnt;
  logic                     inReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[RELEASE_EDGES-2:0], 1'b1};
  end

  assign inReset = ~syncQ[RELEASE_EDGES-1];

  always_ff @(posedge clk) begin
    if (inReset) begin
      if (edgeCnt != CW'(THR)) edgeCnt <= edgeCnt + 1'b1;
    end else begin
      edgeCnt <= '0;
    end
  end

  always_comb begin
    strb.ptrClr  = inReset;
    strb.relEdge = syncQ[RELEASE_EDGES-2] & ~syncQ[RELEASE_EDGES-1];
    // the release edge itself still counts, hence THR-1 before it
    strb.cntMet  = (edgeCnt >= CW'(THR - 1));
  end

  // R1
  ptrClrHeld_chk: assert property (@(posedge clk) disable iff (rstN)
    strb.ptrClr);
endmodule

// File: rtl/rstinit_dp.sv
module rstinit_dp
  import rstinit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  domStrobe_t strb,
  output logic       inReady,
  output logic       outReady,
  output logic       nearEmpty,
  output logic       nearFull,
  output logic       mailFree,
  output logic       shortRst
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReady   <= 1'b0;
      outReady  <= 1'b0;
      nearEmpty <= 1'b0;
      nearFull  <= 1'b1;
      mailFree  <= 1'b1;
    end else if (strb.relEdge) begin
      inReady <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.relEdge) shortRst <= ~strb.cntMet;
  end

  // R2
  initFlags_chk: assert property (@(posedge clk) disable iff (rstN)
    (!inReady && !outReady && !nearEmpty && nearFull && mailFree));

  // R3
  readyRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(strb.relEdge));

  // R3
  releaseSeq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.relEdge |=> (inReady && !strb.ptrClr));

  // R4
  shortHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.relEdge |=> $stable(shortRst));
endmodule

// File: rtl/rstinit_ofs.sv
module rstinit_ofs #(
  parameter int                OW           = 6,
  parameter logic [4*OW-1:0]   OFFSET_TABLE = {6'd32, 6'd16, 6'd8, 6'd4}
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    sel,
  output logic [OW-1:0] offset
);
  always_ff @(posedge rstN) begin
    offset <= OFFSET_TABLE[int'(sel)*OW +: OW];
  end

  // R6
  offsetHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(offset));
endmodule

// File: rtl/dualclk_rst_init.sv
module dualclk_rst_init
  import rstinit_pkg::*;
#(
  parameter int              MIN_EDGES     = 4,
  parameter int              RELEASE_EDGES = 2,
  parameter int              OW            = 6,
  parameter logic [4*OW-1:0] OFFSET_TABLE  = {6'd32, 6'd16, 6'd8, 6'd4}
) (
  input  logic          clkA,
  input  logic          clkB,
  input  logic          rstN,
  input  logic [1:0]    flagSel,
  output logic          ptrClrA,
  output logic          ptrClrB,
  output logic          inReadyA,
  output logic          inReadyB,
  output logic          outReadyA,
  output logic          outReadyB,
  output logic          nearEmptyA,
  output logic          nearEmptyB,
  output logic          nearFullA,
  output logic          nearFullB,
  output logic          mailFreeA,
  output logic          mailFreeB,
  output logic          shortRstA,
  output logic          shortRstB,
  output logic [OW-1:0] flagOffset
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] clkV, ptrClrV, inReadyV, outReadyV, nearEmptyV, nearFullV, mailFreeV, shortV;

  assign clkV = {clkB, clkA};

  for (genvar d = 0; d < NPORT; d++) begin : g_dom
    domStrobe_t strb;

    rstinit_ctl #(.MIN_EDGES(MIN_EDGES), .RELEASE_EDGES(RELEASE_EDGES)) u_ctl (
      .clk (clkV[d]),
      .rstN(rstN),
      .strb(strb)
    );

    rstinit_dp u_dp (
      .clk      (clkV[d]),
      .rstN     (rstN),
      .strb     (strb),
      .inReady  (inReadyV[d]),
      .outReady (outReadyV[d]),
      .nearEmpty(nearEmptyV[d]),
      .nearFull (nearFullV[d]),
      .mailFree (mailFreeV[d]),
      .shortRst (shortV[d])
    );

    assign ptrClrV[d] = strb.ptrClr;
  end

  rstinit_ofs #(.OW(OW), .OFFSET_TABLE(OFFSET_TABLE)) u_ofs (
    .clk   (clkA),
    .rstN  (rstN),
    .sel   (flagSel),
    .offset(flagOffset)
  );

  assign {ptrClrB, ptrClrA}       = ptrClrV;
  assign {inReadyB, inReadyA}     = inReadyV;
  assign {outReadyB, outReadyA}   = outReadyV;
  assign {nearEmptyB, nearEmptyA} = nearEmptyV;
  assign {nearFullB, nearFullA}   = nearFullV;
  assign {mailFreeB, mailFreeA}   = mailFreeV;
  assign {shortRstB, shortRstA}   = shortV;
endmodule

// File: tb/dualclk_rst_init_bench.sv
module dualclk_rst_init_bench;
  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b1;
  logic [1:0] flagSel = 2'd0;
  logic ptrClrA, ptrClrB, inReadyA, inReadyB, outReadyA, outReadyB;
  logic nearEmptyA, nearEmptyB, nearFullA, nearFullB, mailFreeA, mailFreeB;
  logic shortRstA, shortRstB;
  logic [5:0] flagOffset;

  int checks = 0, fails = 0;
  int edgesA = 0, edgesB = 0;
  bit finished = 0;

  always #5 clkA = ~clkA;             // 100 MHz
  initial begin #2; forever #7 clkB = ~clkB; end

  always @(posedge clkA) if (!rstN) edgesA++;
  always @(posedge clkB) if (!rstN) edgesB++;

  dualclk_rst_init u_dualclk_rst_init (.*);

  localparam int NV = 6;
  localparam int LOW_A[NV] = '{6, 3, 4, 10, 2, 5};
  localparam int SEL_V[NV] = '{0, 1, 2, 3, 1, 2};

  function automatic logic [5:0] expOfs(input logic [1:0] s);
    return 6'd4 << s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic dropRst();
    @(negedge clkA);
    edgesA = 0; edgesB = 0;
    rstN = 1'b0;
    #1;
    chk("R1 async ptr clear", {ptrClrB, ptrClrA}, 2'b11);
    chk("R2 reset flags", {inReadyA, outReadyA, nearEmptyA, nearFullA, mailFreeA,
                           inReadyB, outReadyB, nearEmptyB, nearFullB, mailFreeB},
        10'b00011_00011);
  endtask

  task automatic riseAndCheck(input logic [1:0] sel);
    flagSel = sel;
    #1 rstN = 1'b1;
    fork
      begin
        logic expA;
        expA = (edgesA < 4);
        @(posedge clkA); #2;
        chk("R3 port A after 1 edge", {ptrClrA, inReadyA}, 2'b10);
        @(posedge clkA); #2;
        chk("R3 port A after 2 edges", {ptrClrA, inReadyA}, 2'b01);
        chk("R4 R7 port A short status", shortRstA, expA);
      end
      begin
        logic expB;
        expB = (edgesB < 4);
        @(posedge clkB); #2;
        chk("R3 port B after 1 edge", {ptrClrB, inReadyB}, 2'b10);
        @(posedge clkB); #2;
        chk("R3 port B after 2 edges", {ptrClrB, inReadyB}, 2'b01);
        chk("R4 R7 port B short status", shortRstB, expB);
      end
    join
    chk("R5 offset capture", flagOffset, expOfs(sel));
    flagSel = ~sel;
    #30;
    chk("R6 select ignored while high", flagOffset, expOfs(sel));
  endtask

  initial begin
    #2;
    // table walk: hold length in clkA cycles and select code
    for (int i = 0; i < NV; i++) begin
      dropRst();
      repeat (LOW_A[i]) @(negedge clkA);
      #1;
      riseAndCheck(SEL_V[i][1:0]);
    end
    // port B boundary: exactly 4 and exactly 3 clkB edges while low
    for (int n = 4; n >= 3; n--) begin
      dropRst();
      while (edgesB < n) begin @(posedge clkB); #1; end
      #1;
      chk("R4 port B edge count at release", edgesB, n);
      riseAndCheck(2'(n));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule